// File: doc/BRIEF.md
# Double-Edge Capture Lane Serializer

The block samples a 24-bit parallel bus on both edges of its input clock and so builds one 48-bit word per input cycle. The bits sampled at the rising edge form the lower half of the word and the bits sampled at the falling edge form the upper half. Each finished word moves from the input-clock domain into the bit-clock domain. There it is cut into eight 6-bit groups, and each group goes to one serial data lane as a 7-slot frame. A ninth lane carries a clock pattern that marks where each frame starts, so a receiver can find the frame edges.

Every frame begins with a balance slot. With balance mode off, the slot is sent as 0 and the data goes out unchanged. With balance mode on, each lane keeps its own running disparity and decides, frame by frame, whether to invert its six data bits. The balance slot tells the receiver when the data was inverted. The serial side advances one slot on each bit-clock edge that has the bit enable high, and it freezes completely while the enable is low. The data path is a fixed pin-rate stream with no back-pressure. When the input clock runs faster than one frame per input cycle, words are overwritten before they are sent. When both rates match, every word is sent exactly once.

Top module: `dual_edge_lane_serializer`

## Requirements
- R1: A word is made of the `din` value sampled at a rising edge of `pclk` in bits [23:0] and the `din` value sampled at the next falling edge in bits [47:24]. The word is complete at that falling edge.
- R2: Lane k sends its frame MSB first. Slot 0 is the balance slot. Slots 1 to 6 carry word bits k+40, k+32, k+24, k+16, k+8 and k, in that order. Each of these bits is inverted when the balance slot is 1.
- R3: `clk_lane_out` sends 1,1,1,0,0,0,0 over slots 0 to 6 of every frame, and frames follow each other with no gap.
- R4: A new word is loaded into the lane shifters only at slot 0, so every frame carries data from a single word. When one `pclk` period equals seven enabled bit-clock edges, every captured word appears in exactly one frame, in capture order.
- R5: With `bal_en` low when slot 0 is loaded, the balance slot is 0 on every lane and the data is not inverted.
- R6: With `bal_en` high, a lane inverts a frame (balance slot 1) when its running disparity RD is zero, when RD > 0 and the frame's data disparity D > 0, or when RD < 0 and D <= 0. D is the count of ones minus the count of zeros over the six data bits. RD is 0 after reset.
- R7: After a balanced frame, RD becomes RD + D - 1 if the data was not inverted, or RD + 1 - D if it was inverted, limited to the range -6 to +7. RD holds while balance mode is off.
- R8: While `bit_en` is low, all serial outputs and the slot position hold.
- R9: While `rst_n` is low, all lane outputs and the clock lane are 0. The first enabled bit-clock edge after reset sends slot 0 of a frame built from an all-zero word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Input clock; `din` is sampled on both of its edges |
| bit_clk | input | 1 | Fast clock for the serial side |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bit_en | input | 1 | Advances the serial side by one slot when high |
| bal_en | input | 1 | Turns on balance mode; sampled at each slot-0 load |
| din | input | 24 | Parallel input bus |
| lane_out | output | 8 | Serial data lanes, one bit each |
| clk_lane_out | output | 1 | Clock lane carrying the frame marker pattern |

## Verification
A word completed at a falling `pclk` edge lands in the staging register on the third bit-clock edge after that edge, which is two synchronizer stages plus the edge detector. It is loaded on the next enabled slot-0 edge, which is zero to seven enabled edges later, and its seven slots then follow on consecutive enabled edges. The bench does not count this latency. It rebuilds frames from the clock lane, sampling the outputs on falling bit-clock edges and only after edges that had the enable high, and it matches the decoded words in order against the words it sent. Single-edge effects are checked on the first falling edge after the edge that causes them: the reset state, the first slot after reset, and the hold while `bit_en` is low.

// File: rtl/dels_pkg.sv
package dels_pkg;
  // Running-disparity storage, signed; covers -7..+7 deltas and the clamp range
  localparam int RD_W  = 5;
  localparam int RD_HI = 7;
  localparam int RD_LO = -6;
  typedef logic signed [RD_W-1:0] rd_t;
endpackage

// File: rtl/dels_capture.sv
// Double-edge capture in the input-clock domain
module dels_capture #(
  parameter int DIN_W = 24
) (
  input  logic               pclk,
  input  logic               rst_n,
  input  logic [DIN_W-1:0]   din,
  output logic [2*DIN_W-1:0] word_q,
  output logic               word_tgl
);
  logic [DIN_W-1:0] rise_q;

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) rise_q <= '0;
    else        rise_q <= din;
  end

  // Falling edge completes the word and flags it with a toggle
  always_ff @(negedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      word_tgl <= 1'b0;
    end else begin
      word_q   <= {din, rise_q};
      word_tgl <= ~word_tgl;
    end
  end
endmodule

// File: rtl/dels_handoff.sv
// Toggle synchronizer plus staging register in the bit-clock domain
module dels_handoff #(
  parameter int W           = 48,
  parameter int SYNC_STAGES = 2
) (
  input  logic         bit_clk,
  input  logic         rst_n,
  input  logic [W-1:0] word_in,
  input  logic         tgl_in,
  output logic [W-1:0] word_out
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   seen_q;
  logic                   fresh;

  assign fresh = sync_q[SYNC_STAGES-1] ^ seen_q;

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      seen_q   <= 1'b0;
      word_out <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], tgl_in};
      seen_q <= sync_q[SYNC_STAGES-1];
      if (fresh) word_out <= word_in;
    end
  end
endmodule

// File: rtl/dels_frame_timer.sv
// Slot counter and clock-lane pattern
module dels_frame_timer #(
  parameter int FRAME_LEN = 7,
  parameter int CLK_HI    = 3,
  parameter int SLOT_W    = 3
) (
  input  logic              bit_clk,
  input  logic              rst_n,
  input  logic              bit_en,
  output logic [SLOT_W-1:0] slot_q,
  output logic              frame_start,
  output logic              clk_lane_out
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(FRAME_LEN - 1);
  localparam logic [SLOT_W-1:0] HI_N = SLOT_W'(CLK_HI);

  assign frame_start = bit_en && (slot_q == '0);

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q       <= '0;
      clk_lane_out <= 1'b0;
    end else if (bit_en) begin
      slot_q       <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
      clk_lane_out <= (slot_q < HI_N);
    end
  end
endmodule

// File: rtl/dels_lane.sv
// One serial lane: balance decision, disparity tracking, frame shifter
module dels_lane
  import dels_pkg::*;
#(
  parameter int N = 6
) (
  input  logic         bit_clk,
  input  logic         rst_n,
  input  logic         bit_en,
  input  logic         frame_start,
  input  logic         bal_en,
  input  logic [N-1:0] data,
  output logic         lane_o,
  output rd_t          rd_o
);
  localparam int CW = $clog2(N + 1);

  logic [CW-1:0]         ones;
  rd_t                   disp, delta, rd_q;
  logic signed [RD_W:0]  sum;
  logic                  do_inv;
  logic [N:0]            frame;
  logic [N-1:0]          sh_q;

  always_comb begin
    ones = '0;
    for (int i = 0; i < N; i++) ones = ones + CW'(data[i]);
  end

  always_comb begin
    disp   = rd_t'(2 * int'(ones) - N);
    do_inv = bal_en && ((rd_q == '0) || ((rd_q > 0) == (disp > 0)));
    delta  = do_inv ? (rd_t'(1) - disp) : (disp - rd_t'(1));
    sum    = (RD_W+1)'(rd_q) + (RD_W+1)'(delta);
    frame  = {do_inv, data ^ {N{do_inv}}};
  end

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '0;
      sh_q   <= '0;
      lane_o <= 1'b0;
    end else if (frame_start) begin
      lane_o <= frame[N];
      sh_q   <= frame[N-1:0];
      if (bal_en) begin
        if (sum > RD_HI)      rd_q <= rd_t'(RD_HI);
        else if (sum < RD_LO) rd_q <= rd_t'(RD_LO);
        else                  rd_q <= rd_t'(sum);
      end
    end else if (bit_en) begin
      lane_o <= sh_q[N-1];
      sh_q   <= {sh_q[N-2:0], 1'b0};
    end
  end

  assign rd_o = rd_q;
endmodule

// File: rtl/dual_edge_lane_serializer.sv
module dual_edge_lane_serializer
  import dels_pkg::*;
#(
  parameter int DIN_W       = 24,
  parameter int LANES       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             pclk,
  input  logic             bit_clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bal_en,
  input  logic [DIN_W-1:0] din,
  output logic [LANES-1:0] lane_out,
  output logic             clk_lane_out
);
  localparam int WORD_W    = 2 * DIN_W;
  localparam int PER_LANE  = WORD_W / LANES;
  localparam int FRAME_LEN = PER_LANE + 1;
  localparam int SLOT_W    = $clog2(FRAME_LEN);
  localparam int CLK_HI    = (FRAME_LEN - 1) / 2;

  logic [WORD_W-1:0]     cap_word;
  logic                  cap_tgl;
  logic [WORD_W-1:0]     stage_word;
  logic [SLOT_W-1:0]     slot_q;
  logic                  frame_start;
  logic [LANES*RD_W-1:0] lane_rd_flat;

  dels_capture #(.DIN_W(DIN_W)) u_capture (
    .pclk     (pclk),
    .rst_n    (rst_n),
    .din      (din),
    .word_q   (cap_word),
    .word_tgl (cap_tgl)
  );

  dels_handoff #(.W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_handoff (
    .bit_clk  (bit_clk),
    .rst_n    (rst_n),
    .word_in  (cap_word),
    .tgl_in   (cap_tgl),
    .word_out (stage_word)
  );

  dels_frame_timer #(.FRAME_LEN(FRAME_LEN), .CLK_HI(CLK_HI), .SLOT_W(SLOT_W)) u_timer (
    .bit_clk      (bit_clk),
    .rst_n        (rst_n),
    .bit_en       (bit_en),
    .slot_q       (slot_q),
    .frame_start  (frame_start),
    .clk_lane_out (clk_lane_out)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [PER_LANE-1:0] ldata;
    rd_t                 lrd;
    for (genvar j = 0; j < PER_LANE; j++) begin : g_bit
      assign ldata[j] = stage_word[k + LANES*j];
    end
    dels_lane #(.N(PER_LANE)) u_lane (
      .bit_clk     (bit_clk),
      .rst_n       (rst_n),
      .bit_en      (bit_en),
      .frame_start (frame_start),
      .bal_en      (bal_en),
      .data        (ldata),
      .lane_o      (lane_out[k]),
      .rd_o        (lrd)
    );
    assign lane_rd_flat[k*RD_W +: RD_W] = lrd;
  end
endmodule

// File: rtl/dels_checker.sv
module dels_checker
  import dels_pkg::*;
#(
  parameter int LANES     = 8,
  parameter int FRAME_LEN = 7,
  parameter int SLOT_W    = 3
) (
  input logic                  bit_clk,
  input logic                  rst_n,
  input logic                  bit_en,
  input logic                  bal_en,
  input logic [LANES-1:0]      lane_out,
  input logic                  clk_lane_out,
  input logic [SLOT_W-1:0]     slot,
  input logic [LANES*RD_W-1:0] lane_rd
);
  localparam int CLK_HI = (FRAME_LEN - 1) / 2;

  assert_hold_idle_R8: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !bit_en |=> ($stable(lane_out) && $stable(clk_lane_out) && $stable(slot)));

  assert_clk_high_R3: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (bit_en && (int'(slot) < CLK_HI)) |=> clk_lane_out);

  assert_clk_low_R3: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (bit_en && (int'(slot) >= CLK_HI)) |=> !clk_lane_out);

  assert_bal_slot_off_R5: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (bit_en && (slot == '0) && !bal_en) |=> (lane_out == '0));

  assert_slot_range_R4: assert property (@(posedge bit_clk) disable iff (!rst_n)
    int'(slot) < FRAME_LEN);

  always @(posedge bit_clk) begin
    if (rst_n) begin
      for (int k = 0; k < LANES; k++) begin
        assert_rd_range_R7: assert ($signed(lane_rd[k*RD_W +: RD_W]) >= RD_LO &&
                                    $signed(lane_rd[k*RD_W +: RD_W]) <= RD_HI)
          else $error("running disparity out of range on lane %0d", k);
      end
    end
  end
endmodule

bind dual_edge_lane_serializer dels_checker #(
  .LANES(LANES), .FRAME_LEN(FRAME_LEN), .SLOT_W(SLOT_W)
) u_chk (
  .bit_clk      (bit_clk),
  .rst_n        (rst_n),
  .bit_en       (bit_en),
  .bal_en       (bal_en),
  .lane_out     (lane_out),
  .clk_lane_out (clk_lane_out),
  .slot         (slot_q),
  .lane_rd      (lane_rd_flat)
);

// File: tb/tb_dual_edge_lane_serializer.sv
module tb_dual_edge_lane_serializer;
  logic        pclk = 1'b0;
  logic        bit_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b1;
  logic        bal_en = 1'b0;
  logic [23:0] din = '0;
  logic [7:0]  lane_out;
  logic        clk_lane_out;

  int n_checks = 0;
  int n_fail   = 0;

  // 125 MHz bit clock; input clock period is exactly seven bit periods
  always #4  bit_clk = ~bit_clk;
  always #28 pclk    = ~pclk;

  dual_edge_lane_serializer dut (
    .pclk(pclk), .bit_clk(bit_clk), .rst_n(rst_n), .bit_en(bit_en),
    .bal_en(bal_en), .din(din), .lane_out(lane_out), .clk_lane_out(clk_lane_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- frame receiver ----------------
  logic        en_q = 1'b0;
  logic        prev_clk;
  int          pos;
  logic [6:0]  clk_bits;
  logic [6:0]  tx [8];
  int          rd_m [8];
  logic [47:0] rx_q [$];
  logic [47:0] exp_q [$];

  always @(posedge bit_clk) en_q <= bit_en;

  task automatic process_frame();
    logic [47:0] w;
    w = '0;
    check(clk_bits == 7'b1110000, "R3", "clock lane frame pattern", 64'(clk_bits), 64'(7'b1110000));
    for (int k = 0; k < 8; k++) begin
      logic [5:0] dat;
      logic       inv_exp;
      int         disp;
      dat = tx[k][5:0];
      if (bal_en) begin
        // R6 decision table, R7 disparity update from the decoded data
        dat  = tx[k][6] ? ~tx[k][5:0] : tx[k][5:0];
        disp = 2 * $countones(dat) - 6;
        inv_exp = (rd_m[k] == 0) || ((rd_m[k] > 0) == (disp > 0));
        check(tx[k][6] == inv_exp, "R6", "balance slot vs R7 running disparity",
              64'(tx[k][6]), 64'(inv_exp));
        rd_m[k] = rd_m[k] + (inv_exp ? 1 - disp : disp - 1);
        if (rd_m[k] > 7)  rd_m[k] = 7;
        if (rd_m[k] < -6) rd_m[k] = -6;
      end else begin
        check(tx[k][6] == 1'b0, "R5", "balance slot with balance off", 64'(tx[k][6]), 64'd0);
      end
      for (int j = 0; j < 6; j++) w[k + 8*j] = dat[j];  // R2 lane mapping
    end
    rx_q.push_back(w);
  endtask

  always @(negedge bit_clk) begin
    if (!rst_n) begin
      pos      = -1;
      prev_clk = 1'b0;
      for (int k = 0; k < 8; k++) rd_m[k] = 0;
      rx_q.delete();
    end else if (en_q) begin
      if (clk_lane_out && !prev_clk) pos = 0;
      if (pos >= 0) begin
        clk_bits[6-pos] = clk_lane_out;
        for (int k = 0; k < 8; k++) tx[k][6-pos] = lane_out[k];
        pos++;
        if (pos == 7) begin
          process_frame();
          pos = -1;
        end
      end
      prev_clk = clk_lane_out;
    end
  end

  // ---------------- helpers ----------------
  task automatic do_reset(input logic bal);
    @(negedge bit_clk);
    rst_n  = 1'b0;
    bit_en = 1'b1;
    bal_en = bal;
    din    = '0;
    repeat (4) @(negedge bit_clk);
    rst_n = 1'b1;
  endtask

  // R1: lower half before the rising edge, upper half before the falling edge
  task automatic send_word(input logic [47:0] w);
    @(negedge pclk); #14 din = w[23:0];
    @(posedge pclk); #14 din = w[47:24];
    exp_q.push_back(w);
  endtask

  task automatic finish_stream();
    @(negedge pclk); #14 din = '0;
    repeat (160) @(negedge bit_clk);
  endtask

  task automatic verify_seq(input string req);
    int start = -1;
    for (int i = 0; i < rx_q.size(); i++) begin
      if (rx_q[i] == exp_q[0]) begin start = i; break; end
    end
    check(start >= 0, req, "first word found in frames", 64'(start), 64'd0);
    if (start >= 0) begin
      for (int n = 0; n < exp_q.size(); n++) begin
        logic [47:0] act;
        act = (start + n < rx_q.size()) ? rx_q[start + n] : 48'd0;
        check(act == exp_q[n], req, $sformatf("word %0d in order", n), 64'(act), 64'(exp_q[n]));
      end
    end
    exp_q.delete();
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_state();
    @(negedge bit_clk);
    rst_n = 1'b0; bal_en = 1'b0; bit_en = 1'b1;
    repeat (3) @(negedge bit_clk);
    check(lane_out == 8'h00, "R9", "lanes during reset", 64'(lane_out), 64'd0);
    check(clk_lane_out == 1'b0, "R9", "clock lane during reset", 64'(clk_lane_out), 64'd0);
    rst_n = 1'b1;
    @(negedge bit_clk);
    check(clk_lane_out == 1'b1, "R9", "first slot after reset on clock lane", 64'(clk_lane_out), 64'd1);
    check(lane_out == 8'h00, "R5", "balance slot of zero word, balance off", 64'(lane_out), 64'd0);
    // balance on: zero word with RD 0 must be inverted
    do_reset(1'b1);
    @(negedge bit_clk);
    check(lane_out == 8'hFF, "R6", "zero word with RD 0 is inverted", 64'(lane_out), 64'hFF);
  endtask

  task automatic t_plain_stream();
    do_reset(1'b0);
    repeat (20) @(negedge bit_clk);
    send_word(48'h000000_FFFFFF);   // R1 rising half only
    send_word(48'hFFFFFF_000000);   // R1 falling half only
    send_word(48'h123456_ABCDEF);
    send_word(48'h800001_010080);
    for (int i = 0; i < 8; i++) send_word(48'h0101_0101_0101 << i);  // R2 one lane at a time
    finish_stream();
    verify_seq("R4");
  endtask

  task automatic t_balanced_stream();
    do_reset(1'b1);
    repeat (20) @(negedge bit_clk);
    send_word(48'hFFFFFF_FFFFFF);
    send_word(48'h000000_000001);
    send_word(48'hAAAAAA_555555);
    send_word(48'h0F0F0F_F0F0F0);
    send_word(48'hFFFFFF_FFFFFF);
    for (int i = 1; i <= 6; i++) send_word(48'(i) * 48'h0000_1357_9BDF + 48'd1);
    finish_stream();
    verify_seq("R4");
  endtask

  task automatic t_stall();
    logic [7:0] lo_s;
    logic       cl_s;
    do_reset(1'b0);
    send_word(48'h5A5A5A_C3C3C3);
    send_word(48'h3C3C3C_A5A5A5);
    for (int s = 0; s < 4; s++) begin
      repeat (3 + s) @(negedge bit_clk);
      lo_s = lane_out; cl_s = clk_lane_out;
      #1 bit_en = 1'b0;
      for (int c = 0; c < 2 + s; c++) begin
        @(negedge bit_clk);
        check(lane_out == lo_s, "R8", "lanes hold while enable low", 64'(lane_out), 64'(lo_s));
        check(clk_lane_out == cl_s, "R8", "clock lane holds while enable low",
              64'(clk_lane_out), 64'(cl_s));
      end
      #1 bit_en = 1'b1;
    end
    repeat (40) @(negedge bit_clk);
    exp_q.delete();
  endtask

  // ---------------- main / watchdog ----------------
  initial begin
    t_reset_state();
    t_plain_stream();
    t_balanced_stream();
    t_stall();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule